// File: doc/BRIEF.md
# Selectable Event Statistics Counter Bank

This block keeps six event counters for a packet transmit/receive datapath. Each counter can watch one of two event sources. The choice is made by one bit per counter in a shared source-select register, with the bits spaced four apart. The sources are:

- strobes from the datapath: preamble detection, header checks, transmit start and done, gain change, and acknowledge-needed;
- two level inputs, counted on their rising edge: the received signal strength above a programmable threshold, and AGC lock;
- qualified frame-decode events. A frame-decode event needs all of the following: the sender address matches a programmed 32-bit target, the frame is addressed to this station, and the frame is a data frame. One counter also needs a good CRC.

Software reaches the counters and the three configuration words through a plain indexed register port. A write to a counter's index, with any data, sets that counter to zero. Read data appears one cycle after the index is presented. The port has no handshake and never applies back-pressure: a write is accepted in the cycle that `reg_we` is high, and the index may change every cycle. The counters wrap to zero on overflow.

Top module: `evt_stat_bank`

## Requirements
- R1: Six counters sit at indices 26 through 31. Counter k (k = 0..5) is at index 26+k, and reading it returns how many events it has counted since reset or since it was last cleared.
- R2: A write with any data to index 26+k sets counter k to zero in the next cycle. The other counters are not affected.
- R3: When a clear write and a counted event reach the same counter in the same cycle, the clear wins and the counter reads zero.
- R4: The select word is at index 19. Bit 4k chooses the source for counter k: 0 selects the first source set and 1 selects the second. A change to the select word affects events from the next cycle on.
- R5: The first source set, for counters 0 to 3, is: short preamble, long preamble, header strobe, and header strobe AND header valid.
- R6: The first source set, for counters 4 and 5, is a qualified decode event: decode done AND sender-address match AND for-me AND is-data. Counter 5 also requires crc_ok.
- R7: A sender-address match means that `rx_addr2` (the lower 32 bits of the sender MAC) equals the target word at index 7.
- R8: The second source set, in counter order 0 to 5, is: tx start, tx done, RSSI above threshold, gain change, AGC lock, and tx needs ACK.
- R9: RSSI above threshold means `rssi_lvl` is strictly greater than the threshold at index 9. That condition and AGC lock each count once, on their 0-to-1 transition.
- R10: A strobe source adds one to its counter for every cycle in which it is high.
- R11: Read data is registered: `reg_rdata` in cycle t+1 reflects `reg_idx` and the register state in cycle t. Indices 7 and 19 read back in full. Index 9 reads back zero-extended from RSSI_W bits. Any other index outside 26..31 reads zero, and writes to such an index are ignored.
- R12: After reset, all counters, the target, the threshold, the select word and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 6 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| short_pre | input | 1 | Short preamble detected strobe |
| long_pre | input | 1 | Long preamble detected strobe |
| hdr_strobe | input | 1 | Header check done strobe |
| hdr_valid | input | 1 | Header valid qualifier |
| tx_start | input | 1 | Transmit start strobe |
| tx_done | input | 1 | Transmit done strobe |
| rssi_lvl | input | RSSI_W | Current signal strength |
| gain_chg | input | 1 | Gain change strobe |
| agc_lock | input | 1 | AGC lock level |
| tx_need_ack | input | 1 | Transmitted packet needs ACK strobe |
| dec_done | input | 1 | Frame decode finished strobe |
| crc_ok | input | 1 | CRC passed qualifier |
| rx_addr2 | input | 32 | Low 32 bits of the received sender address |
| for_me | input | 1 | Destination address is this station |
| is_data | input | 1 | Frame type is data |

## Verification
The cases hardest to reach from the ports are two timing overlaps. The first is a clear write to a counter in the same cycle as an event that counter is counting. The second is a level source that rises in the cycle when its threshold or select bit changes. To reach them, the bench holds source strobes high for long stretches while it issues clear writes. It also moves the signal strength randomly around a threshold that it rewrites during the run. A run of frame-decode events mixes matching and non-matching sender addresses with random CRC, destination and type qualifiers. A reference model written independently in the bench predicts every read, and the bench compares it against `reg_rdata` each cycle.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
  localparam int NUM_CTR    = 6;
  localparam int IDX_W      = 6;
  localparam int DATA_W     = 32;
  localparam int SEL_STRIDE = 4;
  localparam int IDX_ADDR2  = 7;
  localparam int IDX_THRESH = 9;
  localparam int IDX_SEL    = 19;
  localparam int IDX_CTR0   = 26;

  typedef logic [NUM_CTR-1:0] ev_vec_t;
endpackage

// File: rtl/evstat_cfg.sv
module evstat_cfg
  import evstat_pkg::*;
#(
  parameter int RSSI_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] addr2_tgt,
  output logic [RSSI_W-1:0] rssi_th,
  output logic [DATA_W-1:0] sel_word,
  output ev_vec_t           sel_bits,
  output ev_vec_t           clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr2_tgt <= '0;
      rssi_th   <= '0;
      sel_word  <= '0;
    end else if (reg_we) begin
      if (reg_idx == IDX_W'(IDX_ADDR2))  addr2_tgt <= reg_wdata;
      if (reg_idx == IDX_W'(IDX_THRESH)) rssi_th   <= reg_wdata[RSSI_W-1:0];
      if (reg_idx == IDX_W'(IDX_SEL))    sel_word  <= reg_wdata;
    end
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_dec
    assign sel_bits[k] = sel_word[k*SEL_STRIDE];
    assign clr[k]      = reg_we && (reg_idx == IDX_W'(IDX_CTR0 + k));
  end

  p_clr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  p_tgt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == IDX_W'(IDX_ADDR2)) |=> (addr2_tgt == $past(reg_wdata)));
endmodule

// File: rtl/evstat_src.sv
module evstat_src
  import evstat_pkg::*;
#(
  parameter int RSSI_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              short_pre,
  input  logic              long_pre,
  input  logic              hdr_strobe,
  input  logic              hdr_valid,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic [RSSI_W-1:0] rssi_lvl,
  input  logic              gain_chg,
  input  logic              agc_lock,
  input  logic              tx_need_ack,
  input  logic              dec_done,
  input  logic              crc_ok,
  input  logic [DATA_W-1:0] rx_addr2,
  input  logic              for_me,
  input  logic              is_data,
  input  logic [DATA_W-1:0] addr2_tgt,
  input  logic [RSSI_W-1:0] rssi_th,
  input  ev_vec_t           sel_bits,
  output ev_vec_t           evt
);
  logic    rssi_above, rssi_q, agc_q;
  logic    rssi_rise, agc_rise;
  logic    a2_hit, dec_base;
  ev_vec_t ev_first, ev_second;

  assign rssi_above = rssi_lvl > rssi_th;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rssi_q <= 1'b0;
      agc_q  <= 1'b0;
    end else begin
      rssi_q <= rssi_above;
      agc_q  <= agc_lock;
    end
  end

  assign rssi_rise = rssi_above & ~rssi_q;
  assign agc_rise  = agc_lock & ~agc_q;
  assign a2_hit    = (rx_addr2 == addr2_tgt);
  assign dec_base  = dec_done & a2_hit & for_me & is_data;

  assign ev_first  = {dec_base & crc_ok, dec_base, hdr_strobe & hdr_valid,
                      hdr_strobe, long_pre, short_pre};
  assign ev_second = {tx_need_ack, agc_rise, gain_chg, rssi_rise, tx_done, tx_start};

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_mux
    assign evt[k] = sel_bits[k] ? ev_second[k] : ev_first[k];
  end

  p_rssi_rise_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_rise |=> !rssi_rise);
  p_agc_rise_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    agc_rise |=> !agc_rise);
endmodule

// File: rtl/evstat_ctr.sv
module evstat_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank
  import evstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RSSI_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              short_pre,
  input  logic              long_pre,
  input  logic              hdr_strobe,
  input  logic              hdr_valid,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic [RSSI_W-1:0] rssi_lvl,
  input  logic              gain_chg,
  input  logic              agc_lock,
  input  logic              tx_need_ack,
  input  logic              dec_done,
  input  logic              crc_ok,
  input  logic [31:0]       rx_addr2,
  input  logic              for_me,
  input  logic              is_data
);
  logic [DATA_W-1:0] addr2_tgt, sel_word, rd_next;
  logic [RSSI_W-1:0] rssi_th;
  ev_vec_t           sel_bits, clr, evt;
  logic [CNT_W-1:0]  cnt [NUM_CTR];
  logic              idx_mapped;

  evstat_cfg #(.RSSI_W(RSSI_W)) u_cfg (
    .clk, .rst_n, .reg_we, .reg_idx, .reg_wdata,
    .addr2_tgt, .rssi_th, .sel_word, .sel_bits, .clr
  );

  evstat_src #(.RSSI_W(RSSI_W)) u_src (
    .clk, .rst_n, .short_pre, .long_pre, .hdr_strobe, .hdr_valid,
    .tx_start, .tx_done, .rssi_lvl, .gain_chg, .agc_lock, .tx_need_ack,
    .dec_done, .crc_ok, .rx_addr2, .for_me, .is_data,
    .addr2_tgt, .rssi_th, .sel_bits, .evt
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    evstat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk, .rst_n, .clr(clr[k]), .inc(evt[k]), .cnt(cnt[k])
    );
  end

  always_comb begin
    rd_next    = '0;
    idx_mapped = 1'b0;
    if (reg_idx == IDX_W'(IDX_ADDR2)) begin
      rd_next = addr2_tgt;  idx_mapped = 1'b1;
    end
    if (reg_idx == IDX_W'(IDX_THRESH)) begin
      rd_next = DATA_W'(rssi_th);  idx_mapped = 1'b1;
    end
    if (reg_idx == IDX_W'(IDX_SEL)) begin
      rd_next = sel_word;  idx_mapped = 1'b1;
    end
    for (int k = 0; k < NUM_CTR; k++) begin
      if (reg_idx == IDX_W'(IDX_CTR0 + k)) begin
        rd_next = DATA_W'(cnt[k]);  idx_mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_mapped |=> (reg_rdata == '0));
  p_sel_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_bits[0] && short_pre && !clr[0]) |=> (cnt[0] == $past(cnt[0]) + 1'b1));
  p_ctr_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_W'(IDX_CTR0)) |=> (reg_rdata == DATA_W'($past(cnt[0]))));
endmodule

// File: tb/tb_evt_stat_bank.sv
module tb_evt_stat_bank;
  localparam int CLK_PERIOD = 10;
  localparam int RSSI_W     = 11;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic short_pre = 0, long_pre = 0, hdr_strobe = 0, hdr_valid = 0;
  logic tx_start = 0, tx_done = 0, gain_chg = 0, agc_lock = 0, tx_need_ack = 0;
  logic dec_done = 0, crc_ok = 0, for_me = 0, is_data = 0;
  logic [RSSI_W-1:0] rssi_lvl = '0;
  logic [31:0] rx_addr2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_stat_bank #(.CNT_W(32), .RSSI_W(RSSI_W)) dut (.*);

  // behavioural reference model
  int unsigned m_cnt [6];
  logic [31:0] m_a2, m_sel, exp_rd;
  int unsigned m_th;
  bit m_rssi_q, m_agc_q;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R12";

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_a2 = 0; m_sel = 0; m_th = 0; exp_rd = 0; m_rssi_q = 0; m_agc_q = 0;
  end

  function automatic logic [31:0] model_read(int idx);
    if (idx == 7) return m_a2;
    if (idx == 9) return 32'(m_th);
    if (idx == 19) return m_sel;
    if (idx >= 26 && idx <= 31) return m_cnt[idx-26];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_a2 = 0; m_sel = 0; m_th = 0; exp_rd = 0; m_rssi_q = 0; m_agc_q = 0;
    end else begin
      bit above, dec, ev [6];
      bit alt [6];
      exp_rd = model_read(int'(reg_idx));
      above = int'(rssi_lvl) > m_th;
      dec = dec_done && (rx_addr2 == m_a2) && for_me && is_data;
      alt[0] = tx_start; alt[1] = tx_done; alt[2] = above && !m_rssi_q;
      alt[3] = gain_chg; alt[4] = agc_lock && !m_agc_q; alt[5] = tx_need_ack;
      ev[0] = short_pre; ev[1] = long_pre; ev[2] = hdr_strobe;
      ev[3] = hdr_strobe && hdr_valid; ev[4] = dec; ev[5] = dec && crc_ok;
      for (int k = 0; k < 6; k++) begin
        bit e;
        e = m_sel[4*k] ? alt[k] : ev[k];
        if (reg_we && int'(reg_idx) == 26 + k) m_cnt[k] = 0;
        else if (e) m_cnt[k] = m_cnt[k] + 1;
      end
      m_rssi_q = above;
      m_agc_q = agc_lock;
      if (reg_we && reg_idx == 7) m_a2 = reg_wdata;
      if (reg_we && reg_idx == 9) m_th = int'(reg_wdata[RSSI_W-1:0]);
      if (reg_we && reg_idx == 19) m_sel = reg_wdata;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      summary();
    end
  end

  // compare every cycle at the falling edge, then drive new stimulus
  task automatic step();
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s idx_prev read: actual %h expected %h", cur_req, reg_rdata, exp_rd);
    end
  endtask

  task automatic quiet();
    {short_pre, long_pre, hdr_strobe, hdr_valid, tx_start, tx_done} = '0;
    {gain_chg, agc_lock, tx_need_ack, dec_done, crc_ok, for_me, is_data} = '0;
    reg_we = 0;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    step();
    reg_we = 1; reg_idx = 6'(idx); reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rand_strobes(int n, bit with_dec, logic [31:0] tgt);
    for (int i = 0; i < n; i++) begin
      step();
      {short_pre, long_pre, hdr_strobe, hdr_valid} = 4'($urandom);
      {tx_start, tx_done, gain_chg, tx_need_ack} = 4'($urandom);
      if (($urandom % 4) == 0) agc_lock = ~agc_lock;
      rssi_lvl = RSSI_W'(($urandom % 200) + 400);
      if (with_dec) begin
        {dec_done, crc_ok, for_me, is_data} = 4'($urandom) | 4'b1000;
        rx_addr2 = ($urandom % 2) ? tgt : tgt ^ (32'd1 << ($urandom % 32));
      end else begin
        dec_done = 0;
      end
      reg_we = 0;
      reg_idx = 6'(26 + (i % 6));
    end
    quiet();
  endtask

  initial begin
    quiet();
    // R12: reset state
    repeat (3) step();
    rst_n = 1;
    cur_req = "R12 R11";
    for (int i = 0; i < 64; i++) begin
      step();
      reg_idx = 6'(i);
    end
    // R11: config readback and unmapped writes ignored
    cur_req = "R11 R7";
    wr(7, 32'hb94cb1c1);
    wr(9, 32'hffff_f1f4);
    wr(19, 32'h0000_0000);
    wr(3, 32'hdead_beef);
    wr(40, 32'h1234_5678);
    foreach (m_cnt[i]) begin end
    for (int i = 0; i < 64; i++) begin
      step();
      reg_idx = 6'(i);
    end
    // R5 R10 R1: first source set on the strobe counters
    cur_req = "R5 R10 R1 R4";
    rand_strobes(300, 0, 32'hb94cb1c1);
    // R6 R7: qualified decode events
    cur_req = "R6 R7";
    rand_strobes(400, 1, 32'hb94cb1c1);
    wr(7, 32'h0102_0304);
    rand_strobes(200, 1, 32'h0102_0304);
    // R8 R9 R4: second source set, threshold moved mid-run
    cur_req = "R8 R9 R4";
    wr(19, 32'h0011_1111);
    rand_strobes(300, 1, 32'h0102_0304);
    wr(9, 32'd450);
    rand_strobes(300, 1, 32'h0102_0304);
    wr(19, 32'h0010_1010);
    rand_strobes(200, 1, 32'h0102_0304);
    // R2 R3: clears with strobes held high on every source
    cur_req = "R2 R3";
    wr(19, 32'h0);
    for (int i = 0; i < 120; i++) begin
      step();
      {short_pre, long_pre, hdr_strobe, hdr_valid} = 4'hf;
      {dec_done, crc_ok, for_me, is_data} = 4'hf;
      rx_addr2 = 32'h0102_0304;
      reg_we = (i % 7) == 3;
      reg_wdata = $urandom;
      reg_idx = reg_we ? 6'(26 + ($urandom % 6)) : 6'(26 + (i % 6));
    end
    quiet();
    for (int i = 0; i < 8; i++) begin
      step();
      reg_idx = 6'(26 + (i % 6));
    end
    step();
    summary();
  end
endmodule